// File: doc/BRIEF.md
# Memory-Mapped Bus Decoder with Byte RAM and Switch/LED Port

This block connects an 8-bit processor bus to two targets: a byte-wide RAM and a small switch/LED I/O port. The processor presents an address, a write strobe and write data just after its rising clock edge. The block picks the target from the two most significant address bits. It passes the write strobe only to that target and returns read data to the processor through a multiplexer.

The RAM registers both its reads and its writes, and it runs on the falling clock edge. The processor's address is therefore stable when the RAM samples it, half a cycle before the processor captures the data. Toward the processor, the RAM looks like a memory with asynchronous reads.

The I/O port holds an 8-bit LED register. Any write in the I/O quarter of the address space loads it. A read in that quarter returns the switch inputs, which first pass through a two-flop synchroniser.

Top module: `mmio_bus_fabric`

## Requirements
- R1: While `rst_n` is low, `led_out` is 0x00 and the switch synchroniser holds zero. After reset, an I/O read returns 0x00 until new switch values have passed through the synchroniser.
- R2: An address with bits [7:6] equal to 2'b11 (0xC0 to 0xFF) selects the I/O port. Every other address (0x00 to 0xBF) selects the RAM. This holds at the boundaries 0x3F/0x40, 0xBF/0xC0 and at 0xFF.
- R3: A write cycle (`bus_wr`=1) to an address in 0x00 to 0xBF stores `bus_wdata` at that address. A later read of that address returns the stored byte on `bus_rdata` before the rising edge that ends the read cycle.
- R4: The RAM is read-first. During a write cycle to a RAM address, `bus_rdata` shows the contents that address held before the write.
- R5: A write whose address is in 0xC0 to 0xFF does not strobe the RAM. The bytes stored at 0x00 to 0xBF keep their values.
- R6: A write in 0xC0 to 0xFF loads `bus_wdata` into `led_out` at the rising edge that ends the write cycle, whatever the low six address bits are.
- R7: A cycle that is not an I/O write leaves `led_out` unchanged, including writes to 0x00 to 0xBF.
- R8: A read in 0xC0 to 0xFF returns `sw_in` delayed by two rising edges. A change of `sw_in` first shows on `bus_rdata` in the cycle after the second rising edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; the RAM uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address from the processor |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from the selected target |
| sw_in | input | 8 | Asynchronous switch inputs |
| led_out | output | 8 | LED register |

## Verification
The assertions check on every cycle that the write strobe reaches only the target the address selects, as in R2 and R5. They also check that the LED register loads on I/O writes and holds otherwise (R6 and R7), and that the switch path has a two-edge delay (R8). Only the bench scenarios can show what comes back through the RAM: that stored bytes are read back at the region boundaries, that data arrives within the same processor cycle through the falling-edge RAM, that reads are read-first, and that I/O writes leave RAM bytes intact.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
   typedef enum logic {
      RGN_MEM = 1'b0,
      RGN_IO  = 1'b1
   } region_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
   import mmio_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int RGN_BITS = 2,
   parameter logic [RGN_BITS-1:0] IO_CODE = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output region_e           rgn,
   output logic              mem_we,
   output logic              io_we
);
   localparam int TOP = ADDR_W - 1;

   generate
      if (RGN_BITS < 1 || RGN_BITS >= ADDR_W) begin : g_bad_rgn
         $error("mmio_addr_decode: RGN_BITS must be in 1..ADDR_W-1");
      end
   endgenerate

   assign rgn    = (addr[TOP -: RGN_BITS] == IO_CODE) ? RGN_IO : RGN_MEM;
   assign mem_we = wr && (rgn == RGN_MEM);
   assign io_we  = wr && (rgn == RGN_IO);
endmodule

// File: rtl/mmio_byte_ram.sv
module mmio_byte_ram #(
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter bit READ_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W < 1 || ADDR_W < 1 || ADDR_W > 12) begin : g_bad_size
         $error("mmio_byte_ram: size parameters out of range");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   // Storage is written on the falling edge, half a cycle after the bus settles.
   always_ff @(negedge clk) begin
      if (en && we) mem[addr] <= wdata;
   end

   generate
      if (READ_FIRST) begin : g_read_first
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (en) q <= mem[addr];
         end
      end else begin : g_write_first
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)  q <= '0;
            else if (en) q <= we ? wdata : mem[addr];
         end
      end
   endgenerate
endmodule

// File: rtl/mmio_io_port.sv
module mmio_io_port #(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] sw_in,
   output logic [DATA_W-1:0] led,
   output logic [DATA_W-1:0] sw_sync
);
   localparam int LAST = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mmio_io_port: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] stage [SYNC_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= '0;
      end else begin
         stage[0] <= sw_in;
         for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
      end
   end

   assign sw_sync = stage[LAST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  led <= '0;
      else if (we) led <= wdata;
   end

   generate
      if (SYNC_STAGES == 2) begin : g_chk_sync
         logic [1:0] age;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            age <= '0;
            else if (age != 2'd3)  age <= age + 2'd1;
         end
         // R8: switches reach the read path after exactly two rising edges
         a_r8_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3) |-> (sw_sync == $past(sw_in, 2)));
      end
   endgenerate
endmodule

// File: rtl/mmio_bus_fabric.sv
module mmio_bus_fabric
   import mmio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int RGN_BITS    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit READ_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        sw_in,
   output logic [7:0]        led_out
);
   localparam logic [RGN_BITS-1:0] IO_CODE = '1;
   localparam int TOP = ADDR_W - 1;

   generate
      if (DATA_W != 8 || ADDR_W != 8) begin : g_bad_bus
         $error("mmio_bus_fabric: port widths fixed at 8 bits");
      end
   endgenerate

   region_e           rgn;
   logic              mem_we;
   logic              io_we;
   logic [DATA_W-1:0] ram_q;
   logic [DATA_W-1:0] sw_sync;

   mmio_addr_decode #(
      .ADDR_W  (ADDR_W),
      .RGN_BITS(RGN_BITS),
      .IO_CODE (IO_CODE)
   ) u_decode (
      .addr  (bus_addr),
      .wr    (bus_wr),
      .rgn   (rgn),
      .mem_we(mem_we),
      .io_we (io_we)
   );

   mmio_byte_ram #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .READ_FIRST(READ_FIRST)
   ) u_ram (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rgn == RGN_MEM),
      .we   (mem_we),
      .addr (bus_addr),
      .wdata(bus_wdata),
      .q    (ram_q)
   );

   mmio_io_port #(
      .DATA_W     (DATA_W),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_io (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (io_we),
      .wdata  (bus_wdata),
      .sw_in  (sw_in),
      .led    (led_out),
      .sw_sync(sw_sync)
   );

   assign bus_rdata = (rgn == RGN_IO) ? sw_sync : ram_q;

   // R2: a write below the I/O quarter reaches the RAM strobe
   a_r2_mem_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[TOP -: RGN_BITS] != IO_CODE) |-> mem_we);

   // R5: a write in the I/O quarter never strobes the RAM
   a_r5_ram_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[TOP -: RGN_BITS] == IO_CODE) |-> !mem_we);

   // R6: an I/O write lands in the LED register at the closing edge
   a_r6_led_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[TOP -: RGN_BITS] == IO_CODE) |=> (led_out == $past(bus_wdata)));

   // R7: any other cycle leaves the LEDs alone
   a_r7_led_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr[TOP -: RGN_BITS] == IO_CODE) |=> $stable(led_out));
endmodule

// File: tb/tb_mmio_bus_fabric.sv
module tb_mmio_bus_fabric;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 17;

   typedef struct packed {
      logic       wr;
      logic [7:0] addr;
      logic [7:0] wdata;
      logic       chk;
      logic [7:0] rd;
      logic [7:0] led;
      logic [3:0] req;
   } vec_t;

   // Switches hold 0x5A while the table runs; LEDs start at 0x00.
   localparam vec_t VEC [NV] = '{
      '{1'b1, 8'h3F, 8'h11, 1'b0, 8'h00, 8'h00, 4'd3}, // R3 store below 0x40
      '{1'b1, 8'h40, 8'h22, 1'b0, 8'h00, 8'h00, 4'd3}, // R3 store at 0x40
      '{1'b1, 8'hBF, 8'h33, 1'b0, 8'h00, 8'h00, 4'd7}, // R7 RAM write keeps LEDs
      '{1'b1, 8'h00, 8'h44, 1'b0, 8'h00, 8'h00, 4'd3}, // R3 store at 0x00
      '{1'b0, 8'h3F, 8'h00, 1'b1, 8'h11, 8'h00, 4'd3}, // R3 read 0x3F
      '{1'b0, 8'h40, 8'h00, 1'b1, 8'h22, 8'h00, 4'd2}, // R2 0x40 is RAM
      '{1'b0, 8'hBF, 8'h00, 1'b1, 8'h33, 8'h00, 4'd2}, // R2 0xBF is RAM
      '{1'b0, 8'hC0, 8'h00, 1'b1, 8'h5A, 8'h00, 4'd2}, // R2 0xC0 is I/O
      '{1'b0, 8'hFF, 8'h00, 1'b1, 8'h5A, 8'h00, 4'd8}, // R8 switches at 0xFF
      '{1'b1, 8'hC0, 8'hA5, 1'b1, 8'h5A, 8'hA5, 4'd6}, // R6 LED load at 0xC0
      '{1'b0, 8'hBF, 8'h00, 1'b1, 8'h33, 8'hA5, 4'd5}, // R5 RAM intact
      '{1'b1, 8'hFF, 8'h3C, 1'b0, 8'h00, 8'h3C, 4'd6}, // R6 LED load at 0xFF
      '{1'b1, 8'hBF, 8'h77, 1'b1, 8'h33, 8'h3C, 4'd4}, // R4 old data on write
      '{1'b0, 8'hBF, 8'h00, 1'b1, 8'h77, 8'h3C, 4'd3}, // R3 new data after
      '{1'b1, 8'h7F, 8'h99, 1'b0, 8'h00, 8'h3C, 4'd7}, // R7 LEDs unchanged
      '{1'b0, 8'h7F, 8'h00, 1'b1, 8'h99, 8'h3C, 4'd3}, // R3 read 0x7F
      '{1'b0, 8'h00, 8'h00, 1'b1, 8'h44, 8'h3C, 4'd5}  // R5 low byte intact
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] sw_in = '0;
   logic [7:0] led_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   mmio_bus_fabric dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr   (bus_wr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .sw_in    (sw_in),
      .led_out  (led_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // Entered at rising edge + 1; drives one bus cycle and returns rdata
   // sampled before the edge that closes the cycle, then steps past that edge.
   task automatic bus_cycle(input logic wr, input logic [7:0] addr,
                            input logic [7:0] wdata, output logic [7:0] rd);
      bus_wr    = wr;
      bus_addr  = addr;
      bus_wdata = wdata;
      @(negedge clk);
      #(CLK_PERIOD/4);
      rd = bus_rdata;
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   initial begin
      logic [7:0] rd;
      repeat (3) @(posedge clk);
      #1;
      check("R1 led in reset", led_out, 8'h00);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check("R1 led after reset", led_out, 8'h00);
      bus_cycle(1'b0, 8'hC0, 8'h00, rd);
      check("R1 switch path cleared", rd, 8'h00);

      // R8 latency: switches change, need two rising edges to appear
      sw_in = 8'h5A;
      bus_cycle(1'b0, 8'hC0, 8'h00, rd);
      check("R8 no edge yet", rd, 8'h00);
      bus_cycle(1'b0, 8'hC0, 8'h00, rd);
      check("R8 one edge", rd, 8'h00);
      bus_cycle(1'b0, 8'hC0, 8'h00, rd);
      check("R8 two edges", rd, 8'h5A);

      for (int i = 0; i < NV; i++) begin
         bus_cycle(VEC[i].wr, VEC[i].addr, VEC[i].wdata, rd);
         if (VEC[i].chk)
            check($sformatf("R%0d rdata row %0d", VEC[i].req, i), rd, VEC[i].rd);
         check($sformatf("R%0d led row %0d", VEC[i].req, i), led_out, VEC[i].led);
      end

      // R1: asynchronous reset clears the LED register mid-run
      rst_n = 1'b0;
      #1;
      check("R1 led cleared by reset", led_out, 8'h00);
      #(CLK_PERIOD);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
      finish_run();
   end
endmodule